// File: doc/BRIEF.md
# Cache Control and Non-Cacheable Region Decoder

This unit sits next to a processor core and holds the settings that decide which memory addresses may be cached. Software reaches it through two I/O ports. The first port takes a register index. The second port then writes or reads the register that the index selects. The unit holds three kinds of setting:

- a control byte, which carries two fixed legacy-hole enables, an address-line-20 mask enable, a flush enable and a flush-on-bus-grant option;
- a second control byte, which has one defined bit;
- four programmable windows. Each window is a base address plus a power-of-two size code.

Every physical address presented on `mem_addr` is checked in the same cycle. `noncacheable` rises when any enabled window covers the address, or when an enabled fixed hole covers it. When the flush-on-bus-grant option is set, a rising bus-hold acknowledge produces a one-cycle request to invalidate the whole cache. The cache, the DMA logic and the core are outside this block.

Top module: `cache_cfg_unit`

## Requirements
- R1: Writing I/O port 0x22 loads the index register, and reading port 0x22 returns it. Writing port 0x23 updates the register the index selects, and reading port 0x23 returns that register in the same cycle.
- R2: After a synchronous reset, all of these are zero: the index, both control bytes and all window bytes. In the cycle after reset, `noncacheable`, `flush_req` and `a20_mask_en` are all low.
- R3: Control byte 0 sits at index 0xC0. Its writable bits are 0, 1, 2, 4 and 5, so it reads back masked with 0x37. `a20_mask_en` follows bit 2 from the cycle after the write.
- R4: Control byte 1 sits at index 0xC1. Only bit 7 is stored, and it reads back masked with 0x80.
- R5: Window k (k = 0..3) occupies indices 0xC4+3k, 0xC5+3k and 0xC6+3k. Those bytes hold address bits 31..24, address bits 23..16, and then address bits 15..12 in the upper nibble with the size code in the lower nibble. All three bytes read back unchanged.
- R6: A size code s from 1 to 15 gives a window of 4 KB × 2^(s−1), aligned to its own size, with the low base bits ignored. Size code 0 turns the window off.
- R7: Bit 0 of control byte 0 makes the first 64 KB of every 1 MB block non-cacheable.
- R8: Bit 1 of control byte 0 makes the range 0x000A0000–0x000FFFFF non-cacheable.
- R9: `noncacheable` is the OR of every enabled window match and every enabled fixed hole. It follows `mem_addr` in the same cycle.
- R10: When the index lies outside 0xC0–0xCF, a write to port 0x23 has no effect and a read returns 0xFF. Indices 0xC2 and 0xC3 read 0x00 and ignore writes.
- R11: When bit 5 of control byte 0 is set, a 0→1 change of `hold_ack` drives `flush_req` high for exactly one cycle, starting the cycle after `hold_ack` is first sampled high. When bit 5 is clear, no request is made.
- R12: Accesses to any port other than 0x22 and 0x23 change nothing and read 0x00. While `io_rd` is low, `io_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 32 | Physical address under test |
| hold_ack | input | 1 | Bus-hold acknowledge |
| noncacheable | output | 1 | Address must not be cached |
| flush_req | output | 1 | One-cycle full-cache invalidate request |
| a20_mask_en | output | 1 | Address-line-20 masking enabled |

## Verification
A corrupted window byte or control bit shows up at once on the port-0x23 readback. It also shows up on `noncacheable` in the same cycle that an address near that window boundary is presented. The bench therefore aims random addresses at programmed bases with random low-bit spans, so that a wrong alignment mask flips the decision at the first boundary crossed. A bad edge detector shows up one cycle after `hold_ack` rises, either as a missing pulse or as a pulse lasting two cycles.

// File: rtl/cache_cfg_pkg.sv
`timescale 1ns/1ps
package cache_cfg_pkg;

    localparam int unsigned ADDR_W       = 32;
    localparam int unsigned PAGE_LOG2    = 12;
    localparam int unsigned SIZE_W       = 4;
    localparam int unsigned BASE_W       = ADDR_W - PAGE_LOG2;
    localparam int unsigned REGION_BYTES = 3;

    localparam logic [7:0] IDX_CTRL0   = 8'hC0;
    localparam logic [7:0] IDX_CTRL1   = 8'hC1;
    localparam logic [7:0] IDX_REGION0 = 8'hC4;
    localparam logic [3:0] IDX_GROUP   = 4'hC;

    localparam logic [7:0] CTRL0_MASK = 8'h37;

    typedef struct packed {
        logic flush_on_hold;   // bit 5
        logic flush_en;        // bit 4
        logic a20_mask;        // bit 2
        logic hole_vga;        // bit 1
        logic hole_low64k;     // bit 0
    } ctrl0_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
    } region_t;

    function automatic logic [7:0] ctrl0_pack(input ctrl0_t c);
        return {2'b00, c.flush_on_hold, c.flush_en, 1'b0, c.a20_mask, c.hole_vga, c.hole_low64k};
    endfunction

    function automatic ctrl0_t ctrl0_unpack(input logic [7:0] b);
        ctrl0_t c;
        c.flush_on_hold = b[5];
        c.flush_en      = b[4];
        c.a20_mask      = b[2];
        c.hole_vga      = b[1];
        c.hole_low64k   = b[0];
        return c;
    endfunction

    // Window match: address bits above the window size equal the base bits.
    function automatic logic region_hit(input region_t r, input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] keep;
        logic [ADDR_W-1:0] base_full;
        if (r.size == '0) return 1'b0;
        keep      = {ADDR_W{1'b1}} << (PAGE_LOG2 - 1 + 32'(r.size));
        base_full = {r.base, {PAGE_LOG2{1'b0}}};
        return ((a ^ base_full) & keep) == '0;
    endfunction

    function automatic logic low64k_hit(input logic [ADDR_W-1:0] a);
        return a[19:16] == 4'h0;
    endfunction

    function automatic logic vga_hole_hit(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:20] == '0) && (a[19:16] >= 4'hA);
    endfunction

endpackage

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
module cfg_regfile
    import cache_cfg_pkg::*;
#(
    parameter int unsigned IOADDR_W    = 16,
    parameter logic [15:0] IDX_PORT    = 16'h0022,
    parameter logic [15:0] DATA_PORT   = 16'h0023,
    parameter int unsigned NUM_REGIONS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         io_wr,
    input  logic                         io_rd,
    input  logic [IOADDR_W-1:0]          io_addr,
    input  logic [7:0]                   io_wdata,
    output logic [7:0]                   io_rdata,
    output logic [7:0]                   cur_index,
    output ctrl0_t                       ctrl0,
    output logic                         ctrl1_b7,
    output region_t [NUM_REGIONS-1:0]    regions
);
    localparam int unsigned NUM_BYTES = NUM_REGIONS * REGION_BYTES;
    localparam int unsigned SLOT_W    = $clog2(NUM_BYTES);
    localparam logic [7:0]  LAST_IDX  = IDX_REGION0 + 8'(NUM_BYTES - 1);

    logic [7:0]        rbytes [NUM_BYTES];
    logic [SLOT_W-1:0] slot;
    logic              in_group;
    logic              region_sel;
    logic              at_idx_port;
    logic              at_data_port;

    assign at_idx_port  = (io_addr == IOADDR_W'(IDX_PORT));
    assign at_data_port = (io_addr == IOADDR_W'(DATA_PORT));
    assign in_group     = (cur_index[7:4] == IDX_GROUP);
    assign region_sel   = (cur_index >= IDX_REGION0) && (cur_index <= LAST_IDX);
    assign slot         = SLOT_W'(cur_index - IDX_REGION0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_index <= '0;
            ctrl0     <= '0;
            ctrl1_b7  <= 1'b0;
            for (int i = 0; i < int'(NUM_BYTES); i++) rbytes[i] <= '0;
        end else if (io_wr) begin
            if (at_idx_port) begin
                cur_index <= io_wdata;
            end else if (at_data_port) begin
                if (cur_index == IDX_CTRL0)      ctrl0    <= ctrl0_unpack(io_wdata);
                else if (cur_index == IDX_CTRL1) ctrl1_b7 <= io_wdata[7];
                else if (region_sel)             rbytes[slot] <= io_wdata;
            end
        end
    end

    always_comb begin
        io_rdata = 8'h00;
        if (io_rd) begin
            if (at_idx_port) begin
                io_rdata = cur_index;
            end else if (at_data_port) begin
                if (!in_group)                   io_rdata = 8'hFF;
                else if (cur_index == IDX_CTRL0) io_rdata = ctrl0_pack(ctrl0);
                else if (cur_index == IDX_CTRL1) io_rdata = {ctrl1_b7, 7'b0};
                else if (region_sel)             io_rdata = rbytes[slot];
            end
        end
    end

    for (genvar g = 0; g < int'(NUM_REGIONS); g++) begin : g_region
        localparam int unsigned B0 = g * REGION_BYTES;
        assign regions[g].base = {rbytes[B0], rbytes[B0+1], rbytes[B0+2][7:4]};
        assign regions[g].size = rbytes[B0+2][3:0];
    end
endmodule

// File: rtl/region_matcher.sv
`timescale 1ns/1ps
module region_matcher
    import cache_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4
) (
    input  region_t [NUM_REGIONS-1:0] regions,
    input  logic [ADDR_W-1:0]         addr,
    output logic [NUM_REGIONS-1:0]    hits
);
    for (genvar g = 0; g < int'(NUM_REGIONS); g++) begin : g_match
        assign hits[g] = region_hit(regions[g], addr);
    end
endmodule

// File: rtl/hold_flush.sv
`timescale 1ns/1ps
module hold_flush (
    input  logic clk,
    input  logic rst,
    input  logic hold_ack,
    input  logic enable,
    output logic flush_req
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= 1'b0;
            flush_req <= 1'b0;
        end else begin
            hold_q    <= hold_ack;
            flush_req <= hold_ack & ~hold_q & enable;
        end
    end
endmodule

// File: rtl/cache_cfg_unit.sv
`timescale 1ns/1ps
module cache_cfg_unit
    import cache_cfg_pkg::*;
#(
    parameter int unsigned IOADDR_W    = 16,
    parameter logic [15:0] IDX_PORT    = 16'h0022,
    parameter logic [15:0] DATA_PORT   = 16'h0023,
    parameter int unsigned NUM_REGIONS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [IOADDR_W-1:0] io_addr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic                hold_ack,
    output logic                noncacheable,
    output logic                flush_req,
    output logic                a20_mask_en
);
    logic [7:0]                cur_index;
    ctrl0_t                    ctrl0;
    logic                      ctrl1_b7;
    region_t [NUM_REGIONS-1:0] regions;
    logic [NUM_REGIONS-1:0]    hits;
    logic                      hole_hit;

    cfg_regfile #(
        .IOADDR_W(IOADDR_W), .IDX_PORT(IDX_PORT),
        .DATA_PORT(DATA_PORT), .NUM_REGIONS(NUM_REGIONS)
    ) regs_i (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cur_index(cur_index), .ctrl0(ctrl0), .ctrl1_b7(ctrl1_b7),
        .regions(regions)
    );

    region_matcher #(.NUM_REGIONS(NUM_REGIONS)) match_i (
        .regions(regions), .addr(mem_addr), .hits(hits)
    );

    hold_flush flush_i (
        .clk(clk), .rst(rst), .hold_ack(hold_ack),
        .enable(ctrl0.flush_on_hold), .flush_req(flush_req)
    );

    assign hole_hit = (ctrl0.hole_low64k & low64k_hit(mem_addr))
                    | (ctrl0.hole_vga    & vga_hole_hit(mem_addr));

    assign noncacheable = (|hits) | hole_hit;
    assign a20_mask_en  = ctrl0.a20_mask;
endmodule

// File: rtl/cache_cfg_chk.sv
`timescale 1ns/1ps
module cache_cfg_chk
    import cache_cfg_pkg::*;
#(
    parameter int unsigned IOADDR_W  = 16,
    parameter logic [15:0] IDX_PORT  = 16'h0022,
    parameter logic [15:0] DATA_PORT = 16'h0023
) (
    input logic                clk,
    input logic                rst,
    input logic                io_wr,
    input logic                io_rd,
    input logic [IOADDR_W-1:0] io_addr,
    input logic [7:0]          io_wdata,
    input logic [7:0]          io_rdata,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                hold_ack,
    input logic                noncacheable,
    input logic                flush_req,
    input logic                a20_mask_en,
    input logic [7:0]          cur_index,
    input ctrl0_t              ctrl0
);
    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!noncacheable && !flush_req && !a20_mask_en));

    // R11
    flush_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);

    // R11
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> ($past(hold_ack) && $past(ctrl0.flush_on_hold)));

    // R11
    flush_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hold_ack) && ctrl0.flush_on_hold) |=> flush_req);

    // R3
    a20_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == IOADDR_W'(DATA_PORT) && cur_index == IDX_CTRL0)
        |=> (a20_mask_en == $past(io_wdata[2])));

    // R10
    oor_read_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == IOADDR_W'(DATA_PORT) && cur_index[7:4] != IDX_GROUP)
        |-> (io_rdata == 8'hFF));

    // R7
    low64k_hole_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl0.hole_low64k && mem_addr[19:16] == 4'h0) |-> noncacheable);

    // R12
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == 8'h00));

    // R1
    index_read_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == IOADDR_W'(IDX_PORT)) |-> (io_rdata == cur_index));
endmodule

bind cache_cfg_unit cache_cfg_chk #(
    .IOADDR_W(IOADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
) chk_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .hold_ack(hold_ack), .noncacheable(noncacheable), .flush_req(flush_req),
    .a20_mask_en(a20_mask_en), .cur_index(cur_index), .ctrl0(ctrl0)
);

// File: tb/cache_cfg_unit_tb.sv
`timescale 1ns/1ps
module cache_cfg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [31:0] mem_addr = 32'h0;
    logic        hold_ack = 1'b0;
    logic        noncacheable;
    logic        flush_req;
    logic        a20_mask_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // bench-side register model
    logic [7:0] m_idx = 8'h00;
    logic [7:0] m_c0  = 8'h00;
    logic [7:0] m_c1  = 8'h00;
    logic [7:0] m_rb [12];

    always #2.5 clk = ~clk;

    cache_cfg_unit dut_i (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .hold_ack(hold_ack), .noncacheable(noncacheable),
        .flush_req(flush_req), .a20_mask_en(a20_mask_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] port);
        if (port == 16'h0022) return m_idx;
        if (port != 16'h0023) return 8'h00;
        if (m_idx[7:4] != 4'hC) return 8'hFF;
        if (m_idx == 8'hC0) return m_c0;
        if (m_idx == 8'hC1) return m_c1;
        if (m_idx < 8'hC4) return 8'h00;
        return m_rb[m_idx - 8'hC4];
    endfunction

    function automatic logic exp_nc(input logic [31:0] a);
        logic hit = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [3:0]  s;
            logic [63:0] base, win, lo;
            s = m_rb[3*k+2][3:0];
            if (s != 0) begin
                base = {32'h0, m_rb[3*k], m_rb[3*k+1], m_rb[3*k+2][7:4], 12'h000};
                win  = 64'd4096 << (s - 1);
                lo   = base - (base % win);
                if ({32'h0, a} >= lo && {32'h0, a} < lo + win) hit = 1'b1;
            end
        end
        if (m_c0[0] && (a % 32'h100000) < 32'h10000) hit = 1'b1;
        if (m_c0[1] && a >= 32'hA0000 && a <= 32'hFFFFF) hit = 1'b1;
        return hit;
    endfunction

    task automatic io_write(input logic [15:0] port, input logic [7:0] d);
        @(negedge clk);
        io_addr = port; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (port == 16'h0022) m_idx = d;
        else if (port == 16'h0023) begin
            if (m_idx == 8'hC0) m_c0 = d & 8'h37;
            else if (m_idx == 8'hC1) m_c1 = d & 8'h80;
            else if (m_idx >= 8'hC4 && m_idx <= 8'hCF) m_rb[m_idx - 8'hC4] = d;
        end
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(16'h0022, idx);
        io_write(16'h0023, d);
    endtask

    task automatic rd_chk(input string req, input logic [15:0] port);
        logic [7:0] d;
        @(negedge clk);
        io_addr = port; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
        chk(req, 32'(d), 32'(exp_read(port)));
    endtask

    task automatic nc_chk(input string req, input logic [31:0] a);
        @(negedge clk);
        mem_addr = a;
        #1 chk(req, 32'(noncacheable), 32'(exp_nc(a)));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 12; i++) m_rb[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        chk("R2 a20", 32'(a20_mask_en), 0);
        chk("R2 flush", 32'(flush_req), 0);
        nc_chk("R2 nc", 32'h0000_0000);
        rd_chk("R2 index", 16'h0022);
        io_write(16'h0022, 8'hC0);
        rd_chk("R2 ctrl0", 16'h0023);

        // R1 index/data access
        io_write(16'h0022, 8'hC5);
        rd_chk("R1 index readback", 16'h0022);
        io_write(16'h0023, 8'h5A);
        rd_chk("R1 data readback", 16'h0023);

        // R3 control 0 mask and a20
        reg_write(8'hC0, 8'hFF);
        rd_chk("R3 ctrl0 mask", 16'h0023);
        chk("R3 a20 set", 32'(a20_mask_en), 1);
        reg_write(8'hC0, 8'h00);
        chk("R3 a20 clear", 32'(a20_mask_en), 0);

        // R4 control 1
        reg_write(8'hC1, 8'hFF);
        rd_chk("R4 ctrl1 mask", 16'h0023);

        // R12 foreign port ignored
        io_write(16'h0024, 8'h11);
        rd_chk("R12 ctrl1 untouched", 16'h0023);
        rd_chk("R12 foreign read", 16'h0024);

        // R10 out-of-range index
        reg_write(8'h50, 8'h77);
        rd_chk("R10 oor read", 16'h0023);
        reg_write(8'hC2, 8'hAB);
        rd_chk("R10 hole read", 16'h0023);
        io_write(16'h0022, 8'hC5);
        rd_chk("R10 region untouched", 16'h0023);

        // R5 R6 windows 128 KB at A0000 and 256 KB at C0000
        reg_write(8'hC4, 8'h00); reg_write(8'hC5, 8'h0A); reg_write(8'hC6, 8'h06);
        reg_write(8'hC7, 8'h00); reg_write(8'hC8, 8'h0C); reg_write(8'hC9, 8'h07);
        io_write(16'h0022, 8'hC6);
        rd_chk("R5 size byte", 16'h0023);
        io_write(16'h0022, 8'hC8);
        rd_chk("R5 mid byte", 16'h0023);
        nc_chk("R6 below", 32'h0009_FFFF);
        nc_chk("R6 win1 lo", 32'h000A_0000);
        nc_chk("R6 win1 hi", 32'h000B_FFFF);
        nc_chk("R9 win2", 32'h000C_0000);
        nc_chk("R6 win2 hi", 32'h000F_FFFF);
        nc_chk("R6 above", 32'h0010_0000);
        chk("R6 directed", 32'(noncacheable), 0);
        reg_write(8'hC6, 8'h00);
        nc_chk("R6 code0 off", 32'h000A_0000);
        chk("R6 code0 directed", 32'(noncacheable), 0);

        // R6 largest and smallest code
        reg_write(8'hCA, 8'h12); reg_write(8'hCB, 8'h34); reg_write(8'hCC, 8'h5F);
        nc_chk("R6 big lo", 32'h1000_0000);
        chk("R6 big directed", 32'(noncacheable), 1);
        nc_chk("R6 big hi", 32'h13FF_FFFF);
        nc_chk("R6 big out", 32'h1400_0000);
        nc_chk("R6 big under", 32'h0FFF_FFFF);
        reg_write(8'hCD, 8'hAB); reg_write(8'hCE, 8'hCD); reg_write(8'hCF, 8'hE1);
        nc_chk("R6 4k in", 32'hABCD_EFFF);
        nc_chk("R6 4k out", 32'hABCD_F000);

        // R7 R8 fixed holes
        reg_write(8'hC0, 8'h01);
        nc_chk("R7 low64k in", 32'h0030_1234);
        chk("R7 directed", 32'(noncacheable), 1);
        nc_chk("R7 low64k out", 32'h0031_0000);
        reg_write(8'hC0, 8'h02);
        nc_chk("R8 vga in", 32'h000A_0000);
        chk("R8 directed", 32'(noncacheable), 1);
        nc_chk("R8 vga high MB", 32'h001A_0000);
        nc_chk("R8 vga below", 32'h0009_FFFF);

        // R11 flush on hold rise
        reg_write(8'hC0, 8'h20);
        @(negedge clk); hold_ack = 1'b1;
        @(negedge clk); chk("R11 pulse", 32'(flush_req), 1);
        @(negedge clk); chk("R11 one cycle", 32'(flush_req), 0);
        @(negedge clk); hold_ack = 1'b0;
        reg_write(8'hC0, 8'h00);
        @(negedge clk); hold_ack = 1'b1;
        @(negedge clk); chk("R11 disabled", 32'(flush_req), 0);
        @(negedge clk); chk("R11 disabled2", 32'(flush_req), 0);
        hold_ack = 1'b0;

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                reg_write(8'hC0 + 8'($urandom % 16), 8'($urandom));
                chk("R3 a20 random", 32'(a20_mask_en), 32'(m_c0[2]));
            end else if (op == 1) begin
                io_write(16'h0022, 8'($urandom));
                rd_chk("R10 random read", 16'h0023);
            end else begin
                int k;
                logic [31:0] base, span;
                k    = int'($urandom % 4);
                base = {m_rb[3*k], m_rb[3*k+1], m_rb[3*k+2][7:4], 12'h000};
                span = (32'h1 << ($urandom % 28)) - 1;
                nc_chk("R9 random addr", base ^ ($urandom & span));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule